// File: doc/BRIEF.md
# Eight-Bit Timer with Shared Assignable Prescaler

This block is an 8-bit up-counter for a small microcontroller core. It counts either internal instruction cycles or transitions on an external clock pin. An 8-bit prescaler sits between the count source and the counter, but it can be lent to the watchdog tick path instead. The prescaler uses one ratio table when it serves the timer and a table one step lower when it serves the watchdog. When the prescaler is away, the timer counts every event, and when the timer owns it, the watchdog ticks pass through with one clock of delay.

The oscillator clock `clk` drives a four-phase sequence. Phases 0 to 3 map to Q1 to Q4, and one instruction cycle lasts four oscillator periods. The external pin first passes through a two-flop synchronizer. It is then sampled only on Q2 and Q4. A level must therefore be held for at least two oscillator periods to be counted. Software writes the control byte, the counter and the overflow flag through one write port. A write to the counter holds the count still for two instruction cycles.

Top module: `tmr_shared_presc`

## Requirements
- R1: While reset is asserted, `ctrl_o` reads 0x3F (bits 5:0 set, bits 7:6 zero), `count_o` reads 0 and `ovf_o` reads 0.
- R2: `wr_addr` 0 writes the control byte, whose fields are: bit 5 source (1 = external pin), bit 4 polarity (1 = falling edge), bit 3 owner (1 = watchdog), bits 2:0 rate code. `wr_addr` 1 writes the counter. `wr_addr` 2 writes the flag with `wr_data[0]`. The control byte reads back on `ctrl_o`.
- R3: With the internal source, the counter advances once per instruction cycle (every fourth clock). The ratio is 1:1 whenever the watchdog owns the prescaler.
- R4: With the prescaler owned by the timer, rate code c divides the count events by 2^(c+1), giving ratios from 1:2 to 1:256.
- R5: With the prescaler owned by the watchdog, rate code c makes `wdt_tick_o` pulse once per 2^c pulses of `wdt_tick_i`.
- R6: With the prescaler owned by the timer, `wdt_tick_o` equals `wdt_tick_i` delayed by one clock.
- R7: With the external source, the counter counts rising pin edges when the polarity bit is 0 and falling pin edges when it is 1.
- R8: The synchronized pin is sampled only on phases Q2 and Q4. A level held for two clocks is always counted. A one-clock pulse that falls between samples is not counted.
- R9: A counter write loads the value, clears the prescaler and discards count events for the next two instruction cycles.
- R10: An increment from 0xFF wraps to 0x00 and sets the sticky flag `ovf_o`. A counter write never sets the flag, and only a flag write changes it.
- R11: `icyc_o` is high during Q4 only, once in every four clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write target: 0 control, 1 counter, 2 flag |
| wr_data | input | 8 | Write data |
| ext_clk_i | input | 1 | External count pin, asynchronous |
| wdt_tick_i | input | 1 | Raw watchdog tick, one clock wide |
| wdt_tick_o | output | 1 | Prescaled watchdog tick |
| count_o | output | 8 | Counter value |
| ovf_o | output | 1 | Sticky overflow flag |
| ctrl_o | output | 8 | Control byte read-back |
| icyc_o | output | 1 | High during phase Q4 |

## Verification
A write lands on the clock edge after it is driven. When that edge falls in Q4, internal increments appear at edges 12, 16, 20 and so on after the write, so a window of 4·(n+2) edges contains exactly n events. The bench aligns every timed write on `icyc_o` and samples on the falling edge after the last edge of the window. Watchdog ticks are counted one per clock on falling edges, and the window runs past the last input pulse to cover the one-clock output register. External pulses are given at least ten clocks after the last edge to pass the synchronizer and the phase sampler before the counter is read.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam int RATE_W  = 3;
  localparam int PSC_W   = 1 << RATE_W;
  localparam int TMR_W   = 8;
  localparam int DATA_W  = 8;
  localparam int PH_W    = 2;
  localparam int INH_CYC = 2;
  localparam int INH_W   = $clog2(INH_CYC + 1);
  localparam int ADDR_W  = 2;

  typedef struct packed {
    logic              src_ext;
    logic              edge_fall;
    logic              psc_wdt;
    logic [RATE_W-1:0] rate;
  } tp_ctrl_t;

  localparam int CTRL_W = $bits(tp_ctrl_t);
  localparam tp_ctrl_t CTRL_RST = '{src_ext: 1'b1, edge_fall: 1'b1,
                                    psc_wdt: 1'b1, rate: '1};

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CNT  = 2'd1,
    ADDR_FLAG = 2'd2
  } tp_addr_e;
endpackage

// File: rtl/tp_phase_gen.sv
module tp_phase_gen #(
  parameter int PH_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n_o,
  output logic icyc_evt_o,
  output logic sample_en_o
);
  logic [1:0]      rs_q;
  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n_o = rs_q[1];

  always_comb ph_d = ph_q + 1'b1;

  always_ff @(posedge clk or negedge rst_sync_n_o) begin
    if (!rst_sync_n_o) ph_q <= '0;
    else               ph_q <= ph_d;
  end

  // last phase closes the instruction cycle; odd phases are the sample points
  assign icyc_evt_o  = (ph_q == '1);
  assign sample_en_o = ph_q[0];

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_sync_n_o)
    icyc_evt_o |=> (!icyc_evt_o && !sample_en_o)); // R11
endmodule

// File: rtl/tp_edge_sync.sv
module tp_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en_i,
  input  logic invert_i,
  input  logic pin_i,
  output logic evt_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   lvl;
  logic                   samp_q;
  logic                   samp_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb sync_d = pin_i;
    end else begin : g_many
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], pin_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  always_comb begin
    lvl    = sync_q[SYNC_STAGES-1] ^ invert_i;
    samp_d = sample_en_i ? lvl : samp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) samp_q <= 1'b0;
    else        samp_q <= samp_d;
  end

  assign evt_o = sample_en_i & lvl & ~samp_q;

  AST_EVT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> !evt_o); // R8
endmodule

// File: rtl/tp_prescaler.sv
module tp_prescaler #(
  parameter int RATE_W = 3,
  parameter int PSC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              evt_i,
  input  logic              to_wdt_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] psc_d;
  logic [PSC_W:0]   pow_w;
  logic [PSC_W:0]   pow_t;
  logic [PSC_W-1:0] mask;

  always_comb begin
    pow_w = (PSC_W+1)'(1) << rate_i;
    pow_t = pow_w << 1;
    mask  = to_wdt_i ? PSC_W'(pow_w - 1'b1) : PSC_W'(pow_t - 1'b1);
  end

  always_comb begin
    psc_d = psc_q;
    if (clr_i)      psc_d = '0;
    else if (evt_i) psc_d = psc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '0;
    else        psc_q <= psc_d;
  end

  assign tick_o = evt_i & ~clr_i & ((psc_q & mask) == mask);

  AST_PSC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (psc_q == '0)); // R9
endmodule

// File: rtl/tmr_shared_presc.sv
module tmr_shared_presc
  import tp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ext_clk_i,
  input  logic              wdt_tick_i,
  output logic              wdt_tick_o,
  output logic [TMR_W-1:0]  count_o,
  output logic              ovf_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              icyc_o
);
  logic rst_sync_n;
  logic icyc_evt;
  logic sample_en;
  logic ext_evt;
  logic psc_tick;

  tp_ctrl_t         ctrl_q,  ctrl_d;
  logic [TMR_W-1:0] cnt_q,   cnt_d;
  logic             ovf_q,   ovf_d;
  logic [INH_W-1:0] inh_q,   inh_d;
  logic             wdt_q,   wdt_d;

  logic wr_ctrl, wr_cnt, wr_flag;
  logic src_evt, tmr_evt, psc_evt, psc_clr, tmr_inc;

  tp_phase_gen #(.PH_W(PH_W)) u_phase (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_sync_n_o (rst_sync_n),
    .icyc_evt_o   (icyc_evt),
    .sample_en_o  (sample_en)
  );

  tp_edge_sync #(.SYNC_STAGES(2)) u_sync (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sample_en_i (sample_en),
    .invert_i    (ctrl_q.edge_fall),
    .pin_i       (ext_clk_i),
    .evt_o       (ext_evt)
  );

  tp_prescaler #(.RATE_W(RATE_W), .PSC_W(PSC_W)) u_psc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr_i    (psc_clr),
    .evt_i    (psc_evt),
    .to_wdt_i (ctrl_q.psc_wdt),
    .rate_i   (ctrl_q.rate),
    .tick_o   (psc_tick)
  );

  // write decode
  always_comb begin
    wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
    wr_cnt  = wr_en && (wr_addr == ADDR_CNT);
    wr_flag = wr_en && (wr_addr == ADDR_FLAG);
  end

  // event routing through the shared prescaler
  always_comb begin
    src_evt = ctrl_q.src_ext ? ext_evt : icyc_evt;
    tmr_evt = src_evt && (inh_q == '0);
    psc_evt = ctrl_q.psc_wdt ? wdt_tick_i : tmr_evt;
    psc_clr = wr_ctrl || wr_cnt;
    tmr_inc = ctrl_q.psc_wdt ? tmr_evt : psc_tick;
    wdt_d   = ctrl_q.psc_wdt ? psc_tick : wdt_tick_i;
  end

  // next state
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = tp_ctrl_t'(wr_data[CTRL_W-1:0]);

    cnt_d = cnt_q;
    if (wr_cnt)       cnt_d = wr_data[TMR_W-1:0];
    else if (tmr_inc) cnt_d = cnt_q + 1'b1;

    ovf_d = ovf_q;
    if (tmr_inc && !wr_cnt && (cnt_q == '1)) ovf_d = 1'b1;
    else if (wr_flag)                        ovf_d = wr_data[0];

    inh_d = inh_q;
    if (wr_cnt)                          inh_d = INH_W'(INH_CYC);
    else if (icyc_evt && (inh_q != '0))  inh_d = inh_q - 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q <= CTRL_RST;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      inh_q  <= '0;
      wdt_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
      inh_q  <= inh_d;
      wdt_q  <= wdt_d;
    end
  end

  assign wdt_tick_o = wdt_q;
  assign count_o    = cnt_q;
  assign ovf_o      = ovf_q;
  assign ctrl_o     = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
  assign icyc_o     = icyc_evt;

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((cnt_q == '1) && tmr_inc && !wr_cnt) |=> ((cnt_q == '0) && ovf_q)); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ovf_q && !wr_flag) |=> ovf_q); // R10
  AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((inh_q != '0) && !wr_cnt) |=> $stable(cnt_q)); // R9
  AST_WDT_BYPASS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctrl_q.psc_wdt |=> (wdt_tick_o == $past(wdt_tick_i))); // R6
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_cnt |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1))); // R3
endmodule

// File: tb/test_tmr_shared_presc.sv
module test_tmr_shared_presc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       ext_clk_i = 1'b1;
  logic       wdt_tick_i = 1'b0;
  logic       wdt_tick_o;
  logic [7:0] count_o;
  logic       ovf_o;
  logic [7:0] ctrl_o;
  logic       icyc_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  tmr_shared_presc i_tmr_shared_presc (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ext_clk_i(ext_clk_i), .wdt_tick_i(wdt_tick_i),
    .wdt_tick_o(wdt_tick_o), .count_o(count_o), .ovf_o(ovf_o),
    .ctrl_o(ctrl_o), .icyc_o(icyc_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cbyte(input int src, input int fall, input int wdt, input int rate);
    return 8'((src << 5) | (fall << 4) | (wdt << 3) | rate);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // write lands on the Q4 edge; returns one falling edge after it
  task automatic wr_aligned(input logic [1:0] a, input logic [7:0] d);
    do @(negedge clk); while (icyc_o !== 1'b1);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulses(input int n, input logic idle);
    for (int p = 0; p < n; p++) begin
      ext_clk_i = ~idle; repeat (3) @(negedge clk);
      ext_clk_i = idle;  repeat (3) @(negedge clk);
    end
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 ctrl", ctrl_o, 8'h3F);
    chk("R1 count", count_o, 0);
    chk("R1 flag", ovf_o, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R11 Q4 strobe once per four clocks
    begin
      int hi = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        hi += int'(icyc_o);
      end
      chk("R11 q4 strobes in 40 clocks", hi, 10);
    end

    // R2 control read-back
    wr(2'd0, cbyte(0, 1, 0, 5));
    chk("R2 ctrl read-back", ctrl_o, 8'h15);

    // R3/R4 internal source, both owners, every rate code
    for (int psa = 0; psa < 2; psa++) begin
      for (int r = 0; r < 8; r++) begin
        int rat, n, exp;
        rat = (psa == 1) ? 1 : (2 << r);
        n   = (psa == 1) ? (20 + 40 * r) : (5 * rat + rat / 2);
        exp = n / rat;
        wr(2'd0, cbyte(0, 0, psa, r));
        wr(2'd2, 8'd0);
        wr_aligned(2'd1, 8'd0);
        repeat (4 * (n + 2)) @(posedge clk);
        @(negedge clk);
        if (psa == 1) begin
          chk($sformatf("R3 internal 1:1 code %0d", r), count_o, exp % 256);
          chk($sformatf("R10 flag after %0d events", n), ovf_o, int'(exp > 255));
        end else begin
          chk($sformatf("R4 timer ratio code %0d", r), count_o, exp);
        end
      end
    end

    // R9 write load and two-cycle hold
    wr(2'd0, cbyte(0, 0, 1, 0));
    wr_aligned(2'd1, 8'h10);
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk("R9 held after write", count_o, 8'h10);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R9 counts after hold", count_o, 8'h11);

    // R10 wrap, sticky flag, write rules
    wr(2'd2, 8'd0);
    wr_aligned(2'd1, 8'hFF);
    chk("R10 write sets no flag", ovf_o, 0);
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk("R10 wrap value", count_o, 0);
    chk("R10 flag set", ovf_o, 1);
    wr(2'd1, 8'h05);
    chk("R10 flag survives count write", ovf_o, 1);
    wr(2'd2, 8'd0);
    chk("R10 flag cleared", ovf_o, 0);
    wr(2'd2, 8'd1);
    chk("R10 flag written one", ovf_o, 1);
    wr(2'd2, 8'd0);

    // R5 watchdog ratios
    for (int r = 0; r < 8; r++) begin
      int rat, m, got;
      rat = 1 << r;
      m   = 3 * rat + 1;
      got = 0;
      wr(2'd0, cbyte(0, 0, 1, r));
      for (int i = 0; i < m + 4; i++) begin
        @(negedge clk);
        got += int'(wdt_tick_o);
        wdt_tick_i = (i < m);
      end
      wdt_tick_i = 1'b0;
      chk($sformatf("R5 watchdog ratio code %0d", r), got, m / rat);
    end

    // R6 pass-through when the timer owns the prescaler
    begin
      int mism = 0;
      logic prev = 1'b0;
      wr(2'd0, cbyte(0, 0, 0, 7));
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (wdt_tick_o !== prev) mism++;
        wdt_tick_i = (i % 3 == 0);
        prev = wdt_tick_i;
      end
      wdt_tick_i = 1'b0;
      chk("R6 one-clock pass-through mismatches", mism, 0);
    end

    // R7/R4 external source, both polarities, every timer code
    for (int fall = 0; fall < 2; fall++) begin
      for (int r = 0; r < 8; r++) begin
        int rat, p;
        rat = 2 << r;
        p   = 2 * rat + 1;
        ext_clk_i = logic'(fall);
        wr(2'd0, cbyte(1, fall, 0, r));
        repeat (10) @(negedge clk);
        wr(2'd1, 8'd0);
        repeat (12) @(negedge clk);
        pulses(p, logic'(fall));
        chk($sformatf("R7 ext polarity %0d code %0d", fall, r), count_o, p / rat);
      end
      // R7 external 1:1 with the watchdog owning the prescaler
      wr(2'd0, cbyte(1, fall, 1, 7));
      repeat (10) @(negedge clk);
      wr(2'd1, 8'd0);
      repeat (12) @(negedge clk);
      pulses(7, logic'(fall));
      chk($sformatf("R7 ext 1:1 polarity %0d", fall), count_o, 7);
    end

    // R8 minimum pulse width
    ext_clk_i = 1'b0;
    wr(2'd0, cbyte(1, 0, 1, 0));
    repeat (10) @(negedge clk);
    wr(2'd1, 8'd0);
    repeat (12) @(negedge clk);
    do @(negedge clk); while (icyc_o !== 1'b1);
    @(negedge clk);
    ext_clk_i = 1'b1; @(negedge clk);
    ext_clk_i = 1'b0;
    repeat (10) @(negedge clk);
    chk("R8 one-clock pulse between samples", count_o, 0);
    do @(negedge clk); while (icyc_o !== 1'b1);
    @(negedge clk);
    ext_clk_i = 1'b1; repeat (2) @(negedge clk);
    ext_clk_i = 1'b0;
    repeat (10) @(negedge clk);
    chk("R8 two-clock pulse", count_o, 1);
    do @(negedge clk); while (icyc_o !== 1'b1);
    repeat (2) @(negedge clk);
    ext_clk_i = 1'b1; repeat (2) @(negedge clk);
    ext_clk_i = 1'b0;
    repeat (10) @(negedge clk);
    chk("R8 two-clock pulse shifted", count_o, 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule